// File: doc/BRIEF.md
# CAN Transmit Buffer Status Controller

This block keeps the status of three CAN transmit message buffers: whether each buffer is free or holds a frame waiting to be sent, whether its interrupt is enabled, whether the CPU has asked to cancel it, and whether a cancellation has gone through. Software fills a buffer and then hands it to the protocol engine by writing a one to that buffer's empty flag, which clears the flag. The engine gives the buffer back by pulsing a per-buffer mask, either when the frame has gone out or when a requested cancellation has completed.

From these bits the block drives a single transmit interrupt, a per-buffer signal that locks out CPU access to a buffer while it is handed over, and a per-buffer request vector that tells the engine which buffers it may arbitrate among. Listen mode keeps the engine from starting anything and keeps software from handing over buffers. When initialization mode is fully entered, the flag state is forced back to its reset value.

Top module: `can_txbuf_status`

## Requirements
- R1: After reset all empty flags read 1, and enables, abort requests and abort acknowledges read 0. Bits 7:3 of every read bus are always 0.
- R2: A CPU write with select 0 clears empty flag i for every data bit i that is 1, when writing is allowed and listen mode is off. Data bits that are 0 leave their flag unchanged.
- R3: An engine sent pulse on bit i sets empty flag i in the next cycle. If the CPU clears that flag in the same cycle, the flag still ends up set.
- R4: A CPU write with select 2 sets abort request i for every data bit i that is 1, but only while empty flag i is 0. Data bits that are 0 have no effect.
- R5: An engine abort pulse on bit i sets empty flag i and abort acknowledge i, but only if abort request i is pending. Otherwise the pulse is ignored.
- R6: In every cycle in which empty flag i becomes set, abort request i is cleared.
- R7: In every cycle in which the CPU clears empty flag i, abort acknowledge i is cleared.
- R8: While listen mode is on, CPU writes with select 0 leave the empty flags unchanged, and tx_req_o is all zero.
- R9: While init_req_i and init_ack_i are both 1, all flags return to 1 and all abort bits return to 0. CPU writes to the flag and abort registers are ignored unless both inputs are 0.
- R10: A CPU write with select 1 loads the interrupt enables from data bits 2:0 in any mode. irq_o is 1 exactly when some buffer is both empty and enabled.
- R11: blk_o bit i is 1 exactly while empty flag i is 0.
- R12: tx_req_o bit i is 1 exactly while empty flag i is 0 and listen mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_wr_i | input | 1 | CPU register write strobe |
| cpu_sel_i | input | 2 | Register select: 0 flags, 1 enables, 2 abort requests, 3 none |
| cpu_wdata_i | input | 8 | CPU write data |
| init_req_i | input | 1 | Initialization mode request |
| init_ack_i | input | 1 | Initialization mode acknowledge |
| listen_i | input | 1 | Listen mode active |
| eng_sent_i | input | 3 | One-cycle per-buffer pulse: frame sent |
| eng_abort_i | input | 3 | One-cycle per-buffer pulse: abort completed |
| flag_rd_o | output | 8 | Empty flags read value |
| ien_rd_o | output | 8 | Interrupt enables read value |
| abrq_rd_o | output | 8 | Abort requests read value |
| abak_rd_o | output | 8 | Abort acknowledges read value |
| irq_o | output | 1 | Transmit interrupt |
| blk_o | output | 3 | Per-buffer CPU access block |
| tx_req_o | output | 3 | Per-buffer transmit request to the engine |

## Verification
The assertions assume that the engine pulses are single-cycle masks sampled on the clock. They also assume that an abort pulse matters only when a request is pending, so a stray abort pulse must leave the state alone rather than being forbidden. The random stimulus therefore drives sent and abort masks freely, including on free buffers and in the same cycle as CPU writes. It mixes in listen mode and both partial and full initialization states, so that the priority rules and the gating of writes are exercised together with the normal flow.

// File: rtl/can_txs_pkg.sv
`timescale 1ns/1ps
package can_txs_pkg;

    localparam int unsigned TXS_NBUF = 3;
    localparam int unsigned TXS_DW   = 8;

    typedef enum logic [1:0] {
        SEL_FLAG = 2'd0,
        SEL_IEN  = 2'd1,
        SEL_ABRQ = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic empty;
        logic ien;
        logic abrq;
        logic abak;
    } slot_st_t;

endpackage

// File: rtl/txs_slot.sv
`timescale 1ns/1ps
module txs_slot
    import can_txs_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     hold_rst_i,
    input  logic     wr_ok_i,
    input  logic     listen_i,
    input  logic     wr_flag_i,
    input  logic     wr_ien_i,
    input  logic     wr_abrq_i,
    input  logic     din_i,
    input  logic     sent_i,
    input  logic     aborted_i,
    output slot_st_t st_o
);

    slot_st_t st_d, st_q;
    logic     abt_eff, set_ev, cpu_clr;

    always_comb begin
        st_d    = st_q;
        abt_eff = aborted_i && st_q.abrq;
        set_ev  = sent_i || abt_eff;
        cpu_clr = wr_flag_i && din_i && wr_ok_i && !listen_i && st_q.empty;

        if (wr_ien_i) begin
            st_d.ien = din_i;
        end

        if (set_ev) begin
            st_d.empty = 1'b1;
            st_d.abrq  = 1'b0;
            if (abt_eff) begin
                st_d.abak = 1'b1;
            end
        end else if (cpu_clr) begin
            st_d.empty = 1'b0;
            st_d.abak  = 1'b0;
        end

        if (!set_ev && wr_abrq_i && din_i && wr_ok_i && !st_q.empty) begin
            st_d.abrq = 1'b1;
        end

        if (hold_rst_i) begin
            st_d.empty = 1'b1;
            st_d.abrq  = 1'b0;
            st_d.abak  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{empty: 1'b1, ien: 1'b0, abrq: 1'b0, abak: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;

    // R3: a sent pulse always leaves the buffer free
    p_sent_frees_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sent_i |=> st_q.empty);

    // R4: a cancel request only exists for a handed-over buffer
    p_abrq_sched_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.abrq |-> !st_q.empty);

    // R5: completed cancel frees the buffer and acknowledges
    p_abort_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (aborted_i && st_q.abrq && !hold_rst_i) |=> (st_q.empty && st_q.abak));

    // R6: freeing a buffer drops its cancel request
    p_set_drops_abrq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.empty) |-> !st_q.abrq);

    // R7: handing a buffer over drops its acknowledge
    p_clr_drops_abak_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.empty) |-> !st_q.abak);

    // R8: no hand-over while listening
    p_listen_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (listen_i && st_q.empty) |=> st_q.empty);

    // R9: full initialization forces the reset state
    p_init_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_rst_i |=> (st_q.empty && !st_q.abrq && !st_q.abak));

endmodule

// File: rtl/txs_out.sv
`timescale 1ns/1ps
module txs_out #(
    parameter int unsigned NBUF = 3
) (
    input  logic [NBUF-1:0] empty_i,
    input  logic [NBUF-1:0] ien_i,
    input  logic            listen_i,
    output logic            irq_o,
    output logic [NBUF-1:0] blk_o,
    output logic [NBUF-1:0] tx_req_o
);

    always_comb begin
        irq_o    = |(empty_i & ien_i);
        blk_o    = ~empty_i;
        tx_req_o = listen_i ? '0 : ~empty_i;
    end

endmodule

// File: rtl/can_txbuf_status.sv
`timescale 1ns/1ps
module can_txbuf_status
    import can_txs_pkg::*;
#(
    parameter int unsigned NBUF = TXS_NBUF,
    parameter int unsigned DW   = TXS_DW
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cpu_wr_i,
    input  logic [1:0]      cpu_sel_i,
    input  logic [DW-1:0]   cpu_wdata_i,
    input  logic            init_req_i,
    input  logic            init_ack_i,
    input  logic            listen_i,
    input  logic [NBUF-1:0] eng_sent_i,
    input  logic [NBUF-1:0] eng_abort_i,
    output logic [DW-1:0]   flag_rd_o,
    output logic [DW-1:0]   ien_rd_o,
    output logic [DW-1:0]   abrq_rd_o,
    output logic [DW-1:0]   abak_rd_o,
    output logic            irq_o,
    output logic [NBUF-1:0] blk_o,
    output logic [NBUF-1:0] tx_req_o
);

    localparam int unsigned PAD = DW - NBUF;

    reg_sel_e        sel;
    logic            wr_flag, wr_ien, wr_abrq, wr_ok, hold_rst;
    slot_st_t        st [NBUF];
    logic [NBUF-1:0] empty_v, ien_v, abrq_v, abak_v;

    always_comb begin
        sel      = reg_sel_e'(cpu_sel_i);
        wr_flag  = cpu_wr_i && (sel == SEL_FLAG);
        wr_ien   = cpu_wr_i && (sel == SEL_IEN);
        wr_abrq  = cpu_wr_i && (sel == SEL_ABRQ);
        wr_ok    = !init_req_i && !init_ack_i;
        hold_rst = init_req_i && init_ack_i;
    end

    for (genvar i = 0; i < NBUF; i++) begin : g_slot
        txs_slot u_slot (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .hold_rst_i (hold_rst),
            .wr_ok_i    (wr_ok),
            .listen_i   (listen_i),
            .wr_flag_i  (wr_flag),
            .wr_ien_i   (wr_ien),
            .wr_abrq_i  (wr_abrq),
            .din_i      (cpu_wdata_i[i]),
            .sent_i     (eng_sent_i[i]),
            .aborted_i  (eng_abort_i[i]),
            .st_o       (st[i])
        );
        assign empty_v[i] = st[i].empty;
        assign ien_v[i]   = st[i].ien;
        assign abrq_v[i]  = st[i].abrq;
        assign abak_v[i]  = st[i].abak;
    end

    assign flag_rd_o = {{PAD{1'b0}}, empty_v};
    assign ien_rd_o  = {{PAD{1'b0}}, ien_v};
    assign abrq_rd_o = {{PAD{1'b0}}, abrq_v};
    assign abak_rd_o = {{PAD{1'b0}}, abak_v};

    txs_out #(.NBUF(NBUF)) u_out (
        .empty_i  (empty_v),
        .ien_i    (ien_v),
        .listen_i (listen_i),
        .irq_o    (irq_o),
        .blk_o    (blk_o),
        .tx_req_o (tx_req_o)
    );

    // R1: unimplemented bits never read as 1
    p_pad_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_rd_o[DW-1:NBUF] == '0) && (abak_rd_o[DW-1:NBUF] == '0));

    // R10: enable writes take effect in any mode
    p_ien_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_ien |=> (ien_rd_o[NBUF-1:0] == $past(cpu_wdata_i[NBUF-1:0])));

    // R12: nothing is offered to the engine while listening
    p_listen_noreq_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        listen_i |-> (tx_req_o == '0));

endmodule

// File: tb/can_txbuf_status_tb.sv
`timescale 1ns/1ps
module can_txbuf_status_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] sel = 2'd3;
    logic [7:0] wdata = '0;
    logic       ireq = 1'b0, iack = 1'b0, lsn = 1'b0;
    logic [2:0] sent = '0, abt = '0;
    logic [7:0] flag_rd, ien_rd, abrq_rd, abak_rd;
    logic       irq;
    logic [2:0] blk, txreq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [2:0] m_e, m_i, m_q, m_k;

    always #5 clk = ~clk;

    can_txbuf_status dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cpu_wr_i(wr), .cpu_sel_i(sel),
        .cpu_wdata_i(wdata), .init_req_i(ireq), .init_ack_i(iack),
        .listen_i(lsn), .eng_sent_i(sent), .eng_abort_i(abt),
        .flag_rd_o(flag_rd), .ien_rd_o(ien_rd), .abrq_rd_o(abrq_rd),
        .abak_rd_o(abak_rd), .irq_o(irq), .blk_o(blk), .tx_req_o(txreq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_txreq();
        return lsn ? 3'b000 : ~m_e;
    endfunction

    task automatic compare_all();
        check("R2 flags", flag_rd, {5'b0, m_e});
        check("R10 enables", ien_rd, {5'b0, m_i});
        check("R4 abort requests", abrq_rd, {5'b0, m_q});
        check("R5 abort acks", abak_rd, {5'b0, m_k});
        check("R10 irq", {7'b0, irq}, {7'b0, |(m_e & m_i)});
        check("R11 block", {5'b0, blk}, {5'b0, ~m_e});
        check("R12 tx request", {5'b0, txreq}, {5'b0, exp_txreq()});
    endtask

    // reference next-state computed from the requirements
    task automatic model_next(output logic [2:0] ne, output logic [2:0] ni,
                              output logic [2:0] nq, output logic [2:0] nk);
        bit wok  = !ireq && !iack;
        bit hold = ireq && iack;
        ne = m_e; ni = m_i; nq = m_q; nk = m_k;
        for (int i = 0; i < 3; i++) begin
            bit ae  = abt[i] && m_q[i];
            bit se  = sent[i] || ae;
            bit clr = wr && sel == 2'd0 && wdata[i] && wok && !lsn && m_e[i];
            if (wr && sel == 2'd1) ni[i] = wdata[i];
            if (se) begin
                ne[i] = 1'b1; nq[i] = 1'b0;
                if (ae) nk[i] = 1'b1;
            end else if (clr) begin
                ne[i] = 1'b0; nk[i] = 1'b0;
            end
            if (!se && wr && sel == 2'd2 && wdata[i] && wok && !m_e[i]) nq[i] = 1'b1;
            if (hold) begin
                ne[i] = 1'b1; nq[i] = 1'b0; nk[i] = 1'b0;
            end
        end
    endtask

    // inputs are already driven; advance one cycle and compare
    task automatic step();
        logic [2:0] ne, ni, nq, nk;
        model_next(ne, ni, nq, nk);
        @(posedge clk);
        m_e = ne; m_i = ni; m_q = nq; m_k = nk;
        @(negedge clk);
        compare_all();
    endtask

    task automatic drive(input logic w, input logic [1:0] s, input logic [7:0] d,
                         input logic [2:0] sn, input logic [2:0] ab);
        wr = w; sel = s; wdata = d; sent = sn; abt = ab;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_e = 3'b111; m_i = '0; m_q = '0; m_k = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check("R1 flag reset", flag_rd, 8'h07);
        check("R1 enable reset", ien_rd, 8'h00);
        check("R1 abort reset", abrq_rd | abak_rd, 8'h00);
        check("R1 outputs idle", {irq, blk, txreq}, 8'h00);

        // R2: hand over buffer 1, then a write of zeros
        drive(1, 2'd0, 8'hFA, 0, 0); step();
        check("R2 clear one flag", flag_rd, 8'h05);
        drive(1, 2'd0, 8'h00, 0, 0); step();
        check("R2 zero write", flag_rd, 8'h05);
        // R10: enables and interrupt
        drive(1, 2'd1, 8'h07, 0, 0); step();
        check("R10 irq on", {7'b0, irq}, 8'h01);
        // R4: abort request only where scheduled
        drive(1, 2'd2, 8'h07, 0, 0); step();
        check("R4 abort on scheduled only", abrq_rd, 8'h02);
        // R5 / R6: abort completes
        drive(0, 2'd3, 8'h00, 0, 3'b011); step();
        check("R5 flag after abort", flag_rd, 8'h07);
        check("R5 ack set", abak_rd, 8'h02);
        check("R6 request dropped", abrq_rd, 8'h00);
        // R7: hand over again clears the ack
        drive(1, 2'd0, 8'h02, 0, 0); step();
        check("R7 ack cleared", abak_rd, 8'h00);
        // R3: sent frees buffer 1; set wins over clear of buffer 0
        drive(1, 2'd0, 8'h01, 3'b011, 0); step();
        check("R3 sent and set wins", flag_rd, 8'h07);
        // R8: listen blocks hand-over and requests
        drive(1, 2'd0, 8'h04, 0, 0); step();
        lsn = 1'b1;
        drive(1, 2'd0, 8'h03, 0, 0); step();
        check("R8 listen keeps flags", flag_rd, 8'h03);
        check("R8 no request", {5'b0, txreq}, 8'h00);
        lsn = 1'b0;
        // R9: partial init blocks writes, full init resets
        ireq = 1'b1;
        drive(1, 2'd0, 8'h03, 0, 0); step();
        check("R9 partial init ignores write", flag_rd, 8'h03);
        iack = 1'b1;
        drive(0, 2'd3, 8'h00, 0, 0); step();
        check("R9 full init resets", flag_rd, 8'h07);
        ireq = 1'b0; iack = 1'b0;
        drive(0, 2'd3, 8'h00, 0, 0); step();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            lsn  = ($urandom_range(0, 99) < 10);
            ireq = (r < 8);
            iack = (r < 4) || (r >= 8 && r < 11);
            drive($urandom_range(0, 1), 2'($urandom_range(0, 3)), 8'($urandom),
                  ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000,
                  ($urandom_range(0, 2) == 0) ? 3'($urandom) : 3'b000);
            step();
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            #2000000;
        join_any
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule